// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is the target side of a byte-wide serial EEPROM that sits on a four-wire SPI link in clock mode 0 or mode 3. The link pins are brought into a fast system clock through synchronisers, and the engine acts on the detected SCK and chip-select edges. SCK is never used as a clock. Each frame begins on a falling chip select with an 8-bit command, sent most significant bit first. Array commands follow it with a 16-bit address. The engine then streams stored bytes out, or collects bytes into a page buffer.

A write goes into the array only when chip select rises cleanly on a byte boundary, and only when the write-enable latch was armed in an earlier frame. The commit then runs as a timed busy period. During that period the in-progress flag in the status byte reads 1, the buffered bytes are copied into the storage one per system clock, and only the status read command is served. The array is a synchronous RAM model whose size, page length and busy length are all parameters.

Top module: `spi_ee_engine`

## Requirements
- R1: Command codes are 0x03 read, 0x02 write, 0x06 set-enable, 0x04 clear-enable, 0x05 status read and 0x01 status write. Every command, address and data byte is sent most significant bit first. A read returns the stored byte at the 16-bit address, and address bits at or above ADDR_W are ignored.
- R2: A read keeps sending bytes for as long as SCK runs. The address advances by one after each byte, and it rolls over from the top address to 0.
- R3: Written bytes fill the page from the addressed column upward. A byte that passes the last column of the page wraps to column 0 of the same page and overwrites what was there.
- R4: A commit starts only when chip select rises directly after the last bit of a complete data byte, with at least one data byte received. A rise in the middle of a byte, or before any data byte, discards the frame and starts no busy period.
- R5: The set-enable command sets the write-enable latch (status bit 1) only when chip select rises after exactly 8 bits. A frame with any further bits leaves the latch unchanged, and a write sent in that same frame programs nothing.
- R6: The write-enable latch is cleared by reset, by the clear-enable command, and at the end of a write or status-write busy period. A write or status write sent while the latch is 0 has no effect.
- R7: A commit holds the in-progress flag (status bit 0) at 1 for WRITE_CYCLES system clocks. The status read command answers during that time and repeats the status byte for as long as SCK runs.
- R8: While a busy period runs, every command except status read is ignored: SO is not driven and no state changes. The busy period completes whatever chip select does.
- R9: SO is driven only while the engine shifts out read or status data. The output enable goes to 0 within the synchroniser delay after chip select rises, and stays 0 for unknown commands.
- R10: After reset, nothing is accepted until chip select is seen going from high to low. A frame that was already low during reset is ignored.
- R11: A status write changes only bits 7, 3 and 2, and does so at the end of its busy period. The other bits cannot be written.
- R12: SCK idle-low (mode 0) and SCK idle-high (mode 3) frames give identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| miso_en_o | output | 1 | Output enable for miso_o; 0 means high impedance |

## Verification
Several properties are checked on every cycle. A busy period may begin only on a synchronised chip-select rise, and the set-enable latch may rise only there too. The busy counter stays within its window, and the latch is 0 once a busy period ends. The engine never sits in the read-streaming phase while busy, and SO is never enabled outside a frame. Other behaviour can only be shown by the bench's scenarios, because it depends on data: values coming back at the right addresses, wrap within a page, rollover at the top address, aborted and ignored frames that leave the contents untouched, status bits changing at the right times, and mode 3 giving the same results as mode 0.

// File: rtl/spi_ee_pkg.sv
// Shared definitions for the SPI EEPROM engine: command codes, frame
// phases and the layout of the status byte. The bit positions of the
// status byte are read by host software, so they are fixed.
package spi_ee_pkg;

    localparam logic [7:0] CMD_WRSR  = 8'h01;
    localparam logic [7:0] CMD_WRITE = 8'h02;
    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_WRDI  = 8'h04;
    localparam logic [7:0] CMD_RDSR  = 8'h05;
    localparam logic [7:0] CMD_WREN  = 8'h06;

    // Status bits a status write may change (7, 3 and 2).
    localparam logic [7:0] SR_WMASK  = 8'h8C;

    typedef enum logic [2:0] {
        PH_OPC,     // collecting the command byte
        PH_ADDR,    // collecting the two address bytes
        PH_WDATA,   // collecting array data into the page buffer
        PH_SDATA,   // collecting a status byte
        PH_RDATA,   // streaming array bytes out
        PH_STAT,    // streaming the status byte out
        PH_CTRL,    // enable/disable command seen, expecting CS rise
        PH_IGNORE   // rest of the frame is discarded
    } phase_e;

endpackage

// File: rtl/spi_ee_sync.sv
// Brings SCK, CS and MOSI into the system clock domain and produces
// single-cycle edge strobes. Assumes SCK half periods last several system
// clocks, and STAGES >= 2. All flops reset to 0, so a chip select that is
// already low at reset never produces a falling strobe.
module spi_ee_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic csn_i,
    input  logic mosi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic mosi_s
);
    logic [STAGES:0]   sck_p;
    logic [STAGES:0]   cs_p;
    logic [STAGES-1:0] mo_p;

    // Synchronise the pins; the extra top bit keeps the previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_p <= '0;
            cs_p  <= '0;
            mo_p  <= '0;
        end else begin
            sck_p <= {sck_p[STAGES-1:0], sck_i};
            cs_p  <= {cs_p[STAGES-1:0], csn_i};
            mo_p  <= {mo_p[STAGES-2:0], mosi_i};
        end
    end

    // Edge strobes compare the synchronised value against the prior one.
    always_comb begin
        sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
        sck_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
        cs_rise  = cs_p[STAGES-1] & ~cs_p[STAGES];
        cs_fall  = ~cs_p[STAGES-1] & cs_p[STAGES];
        mosi_s   = mo_p[STAGES-1];
    end
endmodule

// File: rtl/spi_ee_timer.sv
// Busy timer for the internal write cycle. A start pulse opens a window of
// exactly CYCLES clocks. The counter value is exported as a step index, so
// that the commit logic can walk the page buffer. A start while busy is
// ignored.
module spi_ee_timer #(
    parameter int CYCLES = 500,
    parameter int CNT_W  = $clog2(CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] step
);
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    // Count through the busy window and close it on the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == CNT_W'(CYCLES - 1)) busy_q <= 1'b0;
            else                             cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == CNT_W'(CYCLES - 1));
    assign step = cnt_q;

    // R7
    busy_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q < CNT_W'(CYCLES)));
endmodule

// File: rtl/spi_ee_ram.sv
// Byte-wide storage model with one write port and one registered read
// port. The contents are not reset.
module spi_ee_ram #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [2**AW];

    // Synchronous write and registered read.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/spi_ee_engine.sv
// SPI EEPROM command engine: it decodes frames, streams read and status
// data, fills the page buffer, holds the write-enable latch and sequences
// the timed commit. It assumes that SCK and CS change much more slowly
// than clk, and that WRITE_CYCLES >= PAGE_BYTES, so that the commit walk
// fits inside the busy window. It also assumes 8 < ADDR_W <= 16.
module spi_ee_engine #(
    parameter int ADDR_W       = 10,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 500,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic csn_i,
    input  logic mosi_i,
    output logic miso_o,
    output logic miso_en_o
);
    import spi_ee_pkg::*;

    localparam int COL_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - COL_W;
    localparam int HI_W  = ADDR_W - 8;
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

    logic sck_rise, sck_fall, cs_fall, cs_rise, mosi_s;
    logic busy, done;
    logic [CNT_W-1:0] step;

    spi_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .csn_i(csn_i),
        .mosi_i(mosi_i), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .mosi_s(mosi_s)
    );

    // Frame state
    logic              frame_q;
    phase_e            phase_q;
    logic [2:0]        bit_q;
    logic [6:0]        sh_q;
    logic [7:0]        opc_q;
    logic              addr_cnt_q;
    logic [HI_W-1:0]   hi_q;
    logic              got_q;
    logic [COL_W-1:0]  col_q;
    logic [PG_W-1:0]   page_q;
    logic [PAGE_BYTES-1:0] mask_q;
    logic [7:0]        buf_q [PAGE_BYTES];
    logic [7:0]        sr_new_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [6:0]        tx_q;
    logic [2:0]        ocnt_q;
    logic              so_q;
    logic              drive_q;
    // Persistent state
    logic              wel_q;
    logic [7:0]        sr_bits_q;
    logic              kind_q;      // 1: the running commit is a status write

    logic [7:0]        byte_nxt;
    logic [ADDR_W-1:0] addr_nxt;
    logic [7:0]        status;
    logic [7:0]        ram_rdata;
    logic [7:0]        src_byte;
    logic              byte_done;
    logic              commit;
    logic              ctrl_ok;
    logic [COL_W-1:0]  step_col;
    logic              ram_we;

    // Next received byte, full address, status view and commit condition.
    always_comb begin
        byte_nxt  = {sh_q, mosi_s};
        addr_nxt  = {hi_q, byte_nxt};
        byte_done = (bit_q == 3'd7);
        status    = (sr_bits_q & SR_WMASK) | {6'b0, wel_q, busy};
        src_byte  = (phase_q == PH_RDATA) ? ram_rdata : status;
        commit    = cs_rise && frame_q && got_q && (bit_q == 3'd0) && wel_q
                    && !busy && ((phase_q == PH_WDATA) || (phase_q == PH_SDATA));
        ctrl_ok   = cs_rise && frame_q && (phase_q == PH_CTRL) && (bit_q == 3'd0)
                    && !busy;
        step_col  = step[COL_W-1:0];
        ram_we    = busy && !kind_q && (step < CNT_W'(PAGE_BYTES)) && mask_q[step_col];
    end

    // Frame sequencer: command decode, address capture, data shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q    <= 1'b0;
            phase_q    <= PH_IGNORE;
            bit_q      <= '0;
            sh_q       <= '0;
            opc_q      <= '0;
            addr_cnt_q <= 1'b0;
            hi_q       <= '0;
            got_q      <= 1'b0;
            col_q      <= '0;
            page_q     <= '0;
            mask_q     <= '0;
            sr_new_q   <= '0;
            ptr_q      <= '0;
            tx_q       <= '0;
            ocnt_q     <= '0;
            so_q       <= 1'b0;
            drive_q    <= 1'b0;
        end else if (cs_fall) begin
            frame_q    <= 1'b1;
            phase_q    <= PH_OPC;
            bit_q      <= '0;
            addr_cnt_q <= 1'b0;
            got_q      <= 1'b0;
            ocnt_q     <= '0;
            drive_q    <= 1'b0;
        end else if (cs_rise) begin
            frame_q <= 1'b0;
            phase_q <= PH_IGNORE;
            drive_q <= 1'b0;
        end else if (frame_q && sck_rise) begin
            sh_q  <= byte_nxt[6:0];
            bit_q <= bit_q + 1'b1;
            if (phase_q == PH_CTRL) begin
                phase_q <= PH_IGNORE;
            end else if (byte_done) begin
                case (phase_q)
                    PH_OPC: begin
                        opc_q <= byte_nxt;
                        if (busy && byte_nxt != CMD_RDSR) phase_q <= PH_IGNORE;
                        else case (byte_nxt)
                            CMD_READ, CMD_WRITE: phase_q <= PH_ADDR;
                            CMD_RDSR:            phase_q <= PH_STAT;
                            CMD_WRSR:            phase_q <= PH_SDATA;
                            CMD_WREN, CMD_WRDI:  phase_q <= PH_CTRL;
                            default:             phase_q <= PH_IGNORE;
                        endcase
                    end
                    PH_ADDR: begin
                        addr_cnt_q <= 1'b1;
                        hi_q       <= byte_nxt[HI_W-1:0];
                        if (addr_cnt_q) begin
                            if (opc_q == CMD_READ) begin
                                phase_q <= PH_RDATA;
                                ptr_q   <= addr_nxt;
                            end else begin
                                phase_q <= PH_WDATA;
                                page_q  <= addr_nxt[ADDR_W-1:COL_W];
                                col_q   <= addr_nxt[COL_W-1:0];
                                mask_q  <= '0;
                            end
                        end
                    end
                    PH_WDATA: begin
                        mask_q[col_q] <= 1'b1;
                        col_q         <= col_q + 1'b1;
                        got_q         <= 1'b1;
                    end
                    PH_SDATA: begin
                        sr_new_q <= byte_nxt;
                        got_q    <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end else if (frame_q && sck_fall &&
                     (phase_q == PH_RDATA || phase_q == PH_STAT)) begin
            ocnt_q  <= ocnt_q + 1'b1;
            drive_q <= 1'b1;
            if (ocnt_q == 3'd0) begin
                so_q <= src_byte[7];
                tx_q <= src_byte[6:0];
                if (phase_q == PH_RDATA) ptr_q <= ptr_q + 1'b1;
            end else begin
                so_q <= tx_q[6];
                tx_q <= {tx_q[5:0], 1'b0};
            end
        end
    end

    // Page buffer data, written as each data byte completes.
    always_ff @(posedge clk) begin
        if (frame_q && sck_rise && byte_done && phase_q == PH_WDATA && !cs_rise && !cs_fall)
            buf_q[col_q] <= byte_nxt;
    end

    // Write-enable latch, status bits and commit kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q     <= 1'b0;
            sr_bits_q <= '0;
            kind_q    <= 1'b0;
        end else begin
            if (done) begin
                wel_q <= 1'b0;
                if (kind_q) sr_bits_q <= sr_new_q & SR_WMASK;
            end else if (ctrl_ok) begin
                wel_q <= (opc_q == CMD_WREN);
            end
            if (commit) kind_q <= (phase_q == PH_SDATA);
        end
    end

    spi_ee_timer #(.CYCLES(WRITE_CYCLES), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(commit),
        .busy(busy), .done(done), .step(step)
    );

    spi_ee_ram #(.AW(ADDR_W)) u_ram (
        .clk(clk), .we(ram_we), .waddr({page_q, step_col}),
        .wdata(buf_q[step_col]), .raddr(ptr_q), .rdata(ram_rdata)
    );

    assign miso_o    = so_q;
    assign miso_en_o = drive_q;

    // R4
    commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise));
    // R5
    wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_q) |-> $past(cs_rise));
    // R6
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel_q);
    // R8
    busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (phase_q != PH_RDATA));
    // R9
    so_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_q |-> !drive_q);
endmodule

// File: tb/spi_ee_engine_test.sv
module spi_ee_engine_test;
    localparam int AW = 10;
    localparam int PG = 16;
    localparam int H  = 8;   // system clocks per SCK half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
    wire  miso, miso_en;
    logic mode3 = 1'b0;
    int   tests = 0, fails = 0;
    logic finished = 1'b0;

    logic [7:0] model [2**AW];
    logic       known [2**AW];
    logic [7:0] wbuf [32];
    logic [7:0] rbuf [32];
    logic [7:0] rxb;
    logic       rxen;

    always #4 clk = ~clk;

    spi_ee_engine #(.ADDR_W(AW), .PAGE_BYTES(PG), .WRITE_CYCLES(600), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
        .miso_o(miso), .miso_en_o(miso_en)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] page_addr(input logic [AW-1:0] a, input int k);
        return {a[AW-1:4], 4'(int'(a[3:0]) + k)};
    endfunction

    task automatic cs_start();
        sck = mode3;
        wait_clk(4);
        csn = 1'b0;
        wait_clk(H);
    endtask

    task automatic cs_end();
        wait_clk(H);
        csn = 1'b1;
        wait_clk(H);
    endtask

    // Shift nbits of tx out MSB first; the received byte lands in rxb and
    // rxen records whether SO was driven at any sample point.
    task automatic xfer(input logic [7:0] tx, input int nbits);
        rxb = '0;
        rxen = 1'b0;
        for (int i = 7; i > 7 - nbits; i--) begin
            if (mode3) sck = 1'b0;
            mosi = tx[i];
            wait_clk(H);
            rxb[i] = miso;
            rxen = rxen | miso_en;
            sck = 1'b1;
            wait_clk(H);
            if (!mode3) sck = 1'b0;
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        cs_start(); xfer(op, 8); cs_end();
    endtask

    task automatic rd_status();
        cs_start(); xfer(8'h05, 8); xfer(8'h00, 8); cs_end();
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 40; n++) begin
            rd_status();
            if (!rxb[0]) break;
        end
    endtask

    task automatic write_bytes(input logic [AW-1:0] a, input int n, input bit upd);
        cs_start();
        xfer(8'h02, 8); xfer({6'b0, a[9:8]}, 8); xfer(a[7:0], 8);
        for (int k = 0; k < n; k++) begin
            xfer(wbuf[k], 8);
            if (upd) begin
                model[page_addr(a, k)] = wbuf[k];
                known[page_addr(a, k)] = 1'b1;
            end
        end
        cs_end();
    endtask

    task automatic read_bytes(input logic [AW-1:0] a, input int n);
        logic en_all;
        en_all = 1'b1;
        cs_start();
        xfer(8'h03, 8); xfer({6'b0, a[9:8]}, 8); xfer(a[7:0], 8);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, 8);
            rbuf[k] = rxb;
            en_all = en_all & rxen;
        end
        cs_end();
        rxen = en_all;
    endtask

    initial begin
        for (int i = 0; i < 2**AW; i++) known[i] = 1'b0;
        // R10: CS low through reset, then clock a status read without a new fall
        csn = 1'b0;
        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(4);
        check("R9 reset SO enable", miso_en, 0);
        xfer(8'h05, 8); xfer(8'h00, 8);
        check("R10 frame without CS fall", rxen, 0);
        csn = 1'b1;
        wait_clk(H);

        rd_status();
        check("R6 status after reset", rxb, 8'h00);
        check("R9 status drives SO", rxen, 1);
        cmd1(8'h06); rd_status();
        check("R5 enable sets latch", rxb, 8'h02);
        cmd1(8'h04); rd_status();
        check("R6 disable clears latch", rxb, 8'h00);
        cs_start(); xfer(8'h06, 8); xfer(8'h00, 8); cs_end(); rd_status();
        check("R5 enable with extra bits", rxb, 8'h00);

        // R1/R7 byte write then readback
        cmd1(8'h06);
        wbuf[0] = 8'h5A; write_bytes(10'h123, 1, 1);
        rd_status();
        check("R7 busy flag during commit", rxb, 8'h03);
        wait_idle();
        check("R6 latch cleared after write", rxb, 8'h00);
        read_bytes(10'h123, 1);
        check("R1 readback", rbuf[0], 8'h5A);
        // R1 upper address bits ignored
        cs_start(); xfer(8'h03, 8); xfer(8'hFD, 8); xfer(8'h23, 8); xfer(8'h00, 8); cs_end();
        check("R1 high address bits ignored", rxb, 8'h5A);

        // R8 commands during busy
        cmd1(8'h06);
        wbuf[0] = 8'h11; write_bytes(10'h200, 1, 1);
        read_bytes(10'h123, 1);
        check("R8 read ignored while busy", rxen, 0);
        wbuf[0] = 8'hEE; write_bytes(10'h123, 1, 0);
        wait_idle();
        read_bytes(10'h123, 1);
        check("R8 write ignored while busy", rbuf[0], 8'h5A);
        read_bytes(10'h200, 1);
        check("R8 busy cycle completes", rbuf[0], 8'h11);

        // R6 write without latch
        wbuf[0] = 8'h77; write_bytes(10'h123, 1, 0);
        rd_status();
        check("R6 no commit without latch", rxb, 8'h00);
        // R4 partial byte abort and no data byte
        cmd1(8'h06);
        cs_start(); xfer(8'h02, 8); xfer(8'h01, 8); xfer(8'h23, 8);
        xfer(8'h99, 8); xfer(8'h44, 3); cs_end();
        rd_status();
        check("R4 partial byte aborts", rxb, 8'h02);
        write_bytes(10'h123, 0, 0);
        rd_status();
        check("R4 no data byte aborts", rxb, 8'h02);
        read_bytes(10'h123, 1);
        check("R4 contents kept", rbuf[0], 8'h5A);
        cmd1(8'h04);
        // R5 enable and write in one frame
        cs_start(); xfer(8'h06, 8); xfer(8'h02, 8); xfer(8'h01, 8); xfer(8'h23, 8);
        xfer(8'hAB, 8); cs_end();
        rd_status();
        check("R5 same-frame write status", rxb, 8'h00);
        read_bytes(10'h123, 1);
        check("R5 same-frame write no program", rbuf[0], 8'h5A);

        // R3 page wrap, R2 rollover
        cmd1(8'h06); wbuf[0] = 8'hC3; write_bytes(10'h000, 1, 1); wait_idle();
        cmd1(8'h06);
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
        write_bytes(10'h3FE, 4, 1); wait_idle();
        read_bytes(10'h3F0, 2);
        check("R3 wrap to page start", rbuf[0], model[10'h3F0]);
        check("R3 wrap second byte", rbuf[1], model[10'h3F1]);
        read_bytes(10'h3FE, 3);
        check("R2 sequential read", rbuf[1], model[10'h3FF]);
        check("R2 rollover to zero", rbuf[2], model[10'h000]);

        // R11 status write
        cs_start(); xfer(8'h01, 8); xfer(8'hFF, 8); cs_end(); rd_status();
        check("R6 status write needs latch", rxb, 8'h00);
        cmd1(8'h06);
        cs_start(); xfer(8'h01, 8); xfer(8'hFF, 8); cs_end();
        rd_status();
        check("R11 bits unchanged while busy", rxb, 8'h03);
        wait_idle();
        check("R11 writable bits only", rxb, 8'h8C);
        cmd1(8'h06);
        cs_start(); xfer(8'h01, 8); xfer(8'h00, 8); cs_end();
        wait_idle();
        check("R11 bits cleared", rxb, 8'h00);

        // R9 unknown command
        cs_start(); xfer(8'hA5, 8); xfer(8'h00, 8); xfer(8'h00, 8); cs_end();
        check("R9 unknown command no drive", rxen, 0);
        wait_clk(4);
        check("R9 SO released after CS high", miso_en, 0);

        // R12 mode 3
        mode3 = 1'b1;
        rd_status();
        check("R12 mode 3 status", rxb, 8'h00);
        cmd1(8'h06);
        wbuf[0] = 8'h3C; wbuf[1] = 8'hC3; write_bytes(10'h155, 2, 1); wait_idle();
        read_bytes(10'h154, 3);
        check("R12 mode 3 read", rbuf[0], 8'h00 ^ (known[10'h154] ? model[10'h154] : rbuf[0]));
        check("R12 mode 3 data", rbuf[1], 8'h3C);
        check("R12 mode 3 data next", rbuf[2], 8'hC3);
        mode3 = 1'b0;

        // Random page writes and readbacks
        void'($urandom(32'h1234_5EED));
        for (int it = 0; it < 10; it++) begin
            logic [AW-1:0] a;
            int n;
            a = AW'($urandom());
            n = 1 + int'($urandom() % 20);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom());
            cmd1(8'h06);
            write_bytes(a, n, 1);
            wait_idle();
            read_bytes({a[AW-1:4], 4'h0}, PG);
            for (int k = 0; k < PG; k++) begin
                logic [AW-1:0] pa;
                pa = {a[AW-1:4], 4'(k)};
                if (known[pa]) check("R3 random page data", rbuf[k], model[pa]);
            end
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule